// File: doc/BRIEF.md
# Multi-Format Serial Audio Receive Port

This block is the receive side of a serial audio port in slave mode. A bit clock and a frame clock come from an external master, and the block turns the serial data line into parallel samples. The block runs on its own system clock. It brings the bit clock, the frame clock and the data line into that domain through synchronizer flops, and it does all its work on each detected rising edge of the bit clock. In every format, samples are two's complement and arrive most significant bit first.

Three stereo framings are supported: left-justified, I2S and right-justified. In each, the frame clock splits the frame into a left half and a right half. A six-channel single-line mode is also supported. In that mode a frame is 128 bit clocks long, starts on the rising frame-clock edge, and holds six fixed 20-clock slots. Each captured sample appears at the output for one cycle, sign-extended to 24 bits and tagged with its channel number. The block raises error outputs for a reserved format code, for a half-frame too short to hold a sample, and for a frame clock that has stopped.

Top module: `sp_rx_port`

## Requirements
- R1: During and after reset, `sample_vld`, `short_err`, `fmt_err`, `sample_data` and `sample_ch` are all zero.
- R2: With `fmt`=0 (left-justified), the most significant sample bit is the bit sampled on the first rising bit-clock edge that sees the new frame-clock level. The half with the frame clock high is channel 0 and the half with it low is channel 1. Each sample is output once its last bit has been received.
- R3: With `fmt`=1 (I2S), the most significant bit comes one bit clock after the frame-clock transition. The half with the frame clock low is channel 0.
- R4: With `fmt`=2 (right-justified), the least significant bit is the last bit of the half-frame. The sample is output when the next frame-clock transition arrives, with the channel of the half that has just ended (frame clock high is channel 0). Leading bits that are not part of the sample are ignored.
- R5: `width_sel` sets the sample width: code 0 is 16 bits, 1 is 18, 2 is 20 and 3 is 24. `sample_data` carries the sample right-aligned and sign-extended to 24 bits.
- R6: With `fmt`=3 (six-channel line), a frame starts on a rising frame-clock edge, and the falling edge inside the frame has no effect. Channel k takes its bits from clocks 20k to 20k+19, most significant bit first. Channels 0 to 5 are output in that order. Slot bits beyond the sample width, and clocks 120 to 127, are ignored. The sample width is capped at 20 bits.
- R7: Codes 4 to 7 on `fmt` are reserved; code 4 is the second six-channel line variant, which slave mode does not support. While a reserved code is selected, `fmt_err` is high one cycle later and no sample is output.
- R8: A half-frame too short to hold a full sample (fewer than W bit clocks, or W+1 in I2S) pulses `short_err` at the transition that ends it, and that sample is dropped. In the six-channel mode, a frame that ends before all six channels are complete also pulses `short_err`.
- R9: `lrck_lost` goes high after `LOST_CYCLES` system clocks with no frame-clock change and drops at the next change. No sample is output while it is high.
- R10: `sample_vld` is a one-cycle pulse, and `sample_ch` is always below 6 when it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | External serial bit clock |
| lrck | input | 1 | External frame clock |
| sdata | input | 1 | Serial data line |
| fmt | input | 3 | Format code: 0 LJ, 1 I2S, 2 RJ, 3 six-channel line, 4 to 7 reserved |
| width_sel | input | 2 | Sample width code (16, 18, 20 or 24 bits) |
| sample_data | output | 24 | Received sample, sign-extended |
| sample_ch | output | 3 | Channel number of the sample |
| sample_vld | output | 1 | Sample strobe |
| short_err | output | 1 | Pulse marking a half-frame or frame that was too short |
| fmt_err | output | 1 | High while a reserved format is selected |
| lrck_lost | output | 1 | High while the frame clock has stopped |

## Verification
The hardest states to reach are the truncated half-frame and the truncated frame clock. A correct master never produces either one, so neither comes about through normal framing. The bench's half-frame generator takes the length of each half independently, which lets it end the right half early. The boundary cases are then driven deliberately: an I2S half exactly one bit longer than the sample width, and a left-justified half shorter than a 24-bit sample. The bench fills every bit outside the sample field with ones, so a capture window that is off by one position shows up as a wrong value.

// File: rtl/sp_fmt_pkg.sv
package sp_fmt_pkg;

    localparam int unsigned MAX_W = 24;

    localparam logic [2:0] FMT_LJ  = 3'd0;
    localparam logic [2:0] FMT_I2S = 3'd1;
    localparam logic [2:0] FMT_RJ  = 3'd2;
    localparam logic [2:0] FMT_OL1 = 3'd3;

    function automatic logic [4:0] width_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return 5'd16;
            2'd1:    return 5'd18;
            2'd2:    return 5'd20;
            default: return 5'd24;
        endcase
    endfunction

    function automatic logic is_reserved(input logic [2:0] f);
        return f > FMT_OL1;
    endfunction

    // Keep the low w bits and replicate bit w-1 upward.
    function automatic logic [MAX_W-1:0] sign_ext(input logic [MAX_W-1:0] v,
                                                  input logic [4:0] w);
        logic [MAX_W-1:0] r;
        logic             s;
        s = v[w - 5'd1];
        for (int i = 0; i < MAX_W; i++) begin
            r[i] = (i < int'(w)) ? v[i] : s;
        end
        return r;
    endfunction

endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out,
    output logic         rise0
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
        logic                     last0;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.pipe[0] = async_in;
        for (int i = 1; i < int'(STAGES); i++) begin
            s_d.pipe[i] = s_q.pipe[i-1];
        end
        s_d.last0 = s_q.pipe[STAGES-1][0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_out = s_q.pipe[STAGES-1];
    assign rise0    = s_q.pipe[STAGES-1][0] & ~s_q.last0;

    // A rising edge is never detected on two consecutive cycles.
    p_rise_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rise0 |=> !rise0);

endmodule

// File: rtl/sp_lrck_mon.sv
module sp_lrck_mon #(
    parameter int unsigned LOST_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lrck_s,
    output logic lost
);
    localparam int unsigned CW = $clog2(LOST_CYCLES + 1);
    localparam logic [CW-1:0] LIM = CW'(LOST_CYCLES);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
        logic          lost;
    } mon_t;

    mon_t m_d, m_q;

    always_comb begin
        m_d      = m_q;
        m_d.prev = lrck_s;
        if (lrck_s != m_q.prev) begin
            m_d.cnt  = '0;
            m_d.lost = 1'b0;
        end else begin
            if (m_q.cnt != LIM) m_d.cnt = m_q.cnt + 1'b1;
            m_d.lost = (m_d.cnt == LIM);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign lost = m_q.lost;

    // A frame-clock change always clears the lost flag.
    p_lost_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lrck_s != $past(lrck_s)) |=> !lost);

endmodule

// File: rtl/sp_deser.sv
module sp_deser
    import sp_fmt_pkg::*;
#(
    parameter int unsigned SLOT_CLKS = 20,
    parameter int unsigned OL_CH     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             lr_in,
    input  logic             d_in,
    input  logic [2:0]       fmt,
    input  logic [1:0]       wsel,
    input  logic             lost,
    output logic [MAX_W-1:0] data,
    output logic [2:0]       ch,
    output logic             vld,
    output logic             short_err,
    output logic             fmt_err
);
    localparam int unsigned SBW = $clog2(SLOT_CLKS);
    localparam int unsigned SLW = $clog2(OL_CH + 1);
    localparam logic [4:0]     SLOT_W5  = 5'(SLOT_CLKS);
    localparam logic [SBW-1:0] SB_LAST  = SBW'(SLOT_CLKS - 1);
    localparam logic [SLW-1:0] SL_END   = SLW'(OL_CH);

    typedef struct packed {
        logic             primed;
        logic             lr;
        logic             synced;
        logic [7:0]       pos;
        logic [SLW-1:0]   slot;
        logic [SBW-1:0]   sbit;
        logic [SLW-1:0]   olcnt;
        logic [MAX_W-1:0] sh;
        logic [MAX_W-1:0] data;
        logic [2:0]       ch;
        logic             vld;
        logic             shrt;
        logic             ferr;
    } core_t;

    core_t c_d, c_q;

    logic             bad, ol, i2s, rj, edge_seen, fstart;
    logic [4:0]       w, wc;
    logic [8:0]       need, len_prev;
    logic [7:0]       tgt;
    logic [MAX_W-1:0] sh_n;

    always_comb begin
        bad       = is_reserved(fmt);
        ol        = (fmt == FMT_OL1);
        i2s       = (fmt == FMT_I2S);
        rj        = (fmt == FMT_RJ);
        w         = width_of(wsel);
        wc        = (w > SLOT_W5) ? SLOT_W5 : w;
        need      = {4'd0, w} + {8'd0, i2s};
        tgt       = {3'd0, w} - 8'd1 + {7'd0, i2s};
        len_prev  = {1'b0, c_q.pos} + 9'd1;
        sh_n      = {c_q.sh[MAX_W-2:0], d_in};
        edge_seen = c_q.primed && (lr_in != c_q.lr);
        fstart    = edge_seen && lr_in;

        c_d      = c_q;
        c_d.vld  = 1'b0;
        c_d.shrt = 1'b0;
        c_d.ferr = bad;

        if (rise) begin
            c_d.primed = 1'b1;
            c_d.lr     = lr_in;
            c_d.sh     = sh_n;
        end

        if (bad || lost) begin
            c_d.synced = 1'b0;
        end else if (rise) begin
            if (!ol) begin
                // Stereo framings: position counts from each frame-clock transition.
                if (edge_seen) begin
                    c_d.synced = 1'b1;
                    c_d.pos    = '0;
                    if (c_q.synced) begin
                        if (len_prev < need) begin
                            c_d.shrt = 1'b1;
                        end else if (rj) begin
                            c_d.vld  = 1'b1;
                            c_d.data = sign_ext(c_q.sh, w);
                            c_d.ch   = {2'b00, ~c_q.lr};
                        end
                    end
                end else if (c_q.pos != 8'hFF) begin
                    c_d.pos = c_q.pos + 8'd1;
                end
                if (c_d.synced && !rj && c_d.pos == tgt) begin
                    c_d.vld  = 1'b1;
                    c_d.data = sign_ext(sh_n, w);
                    c_d.ch   = {2'b00, i2s ? lr_in : ~lr_in};
                end
            end else begin
                // Six-channel line: slots counted from the rising frame-clock edge.
                if (fstart) begin
                    c_d.synced = 1'b1;
                    c_d.slot   = '0;
                    c_d.sbit   = '0;
                    c_d.olcnt  = '0;
                    if (c_q.synced && c_q.olcnt < SL_END) c_d.shrt = 1'b1;
                end else if (c_q.sbit == SB_LAST) begin
                    c_d.sbit = '0;
                    if (c_q.slot != SL_END) c_d.slot = c_q.slot + 1'b1;
                end else begin
                    c_d.sbit = c_q.sbit + 1'b1;
                end
                if (c_d.synced && c_d.slot < SL_END && c_d.sbit == SBW'(wc - 5'd1)) begin
                    c_d.vld   = 1'b1;
                    c_d.data  = sign_ext(sh_n, wc);
                    c_d.ch    = 3'(c_d.slot);
                    c_d.olcnt = c_q.olcnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign data      = c_q.data;
    assign ch        = c_q.ch;
    assign vld       = c_q.vld;
    assign short_err = c_q.shrt;
    assign fmt_err   = c_q.ferr;

    p_vld_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> !vld);

    p_ch_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (ch < 3'(OL_CH)));

    p_reject_fmt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        is_reserved(fmt) |=> (fmt_err && !vld));

    p_quiet_when_lost_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lost |=> !vld);

    p_drop_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(vld && short_err));

endmodule

// File: rtl/sp_rx_port.sv
module sp_rx_port
    import sp_fmt_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned LOST_CYCLES = 1024,
    parameter int unsigned SLOT_CLKS   = 20,
    parameter int unsigned OL_CH       = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk,
    input  logic        lrck,
    input  logic        sdata,
    input  logic [2:0]  fmt,
    input  logic [1:0]  width_sel,
    output logic [23:0] sample_data,
    output logic [2:0]  sample_ch,
    output logic        sample_vld,
    output logic        short_err,
    output logic        fmt_err,
    output logic        lrck_lost
);
    logic [2:0] pins_s;
    logic       sclk_rise;
    logic       lost;

    sp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sdata, lrck, sclk}),
        .sync_out (pins_s),
        .rise0    (sclk_rise)
    );

    sp_lrck_mon #(.LOST_CYCLES(LOST_CYCLES)) u_mon (
        .clk    (clk),
        .rst_n  (rst_n),
        .lrck_s (pins_s[1]),
        .lost   (lost)
    );

    sp_deser #(.SLOT_CLKS(SLOT_CLKS), .OL_CH(OL_CH)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (sclk_rise),
        .lr_in     (pins_s[1]),
        .d_in      (pins_s[2]),
        .fmt       (fmt),
        .wsel      (width_sel),
        .lost      (lost),
        .data      (sample_data),
        .ch        (sample_ch),
        .vld       (sample_vld),
        .short_err (short_err),
        .fmt_err   (fmt_err)
    );

    assign lrck_lost = lost;

endmodule

// File: tb/sp_rx_port_tb.sv
module sp_rx_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, lrck = 1'b0, sdata = 1'b0;
    logic [2:0]  fmt = 3'd0;
    logic [1:0]  width_sel = 2'd0;
    logic [23:0] sample_data;
    logic [2:0]  sample_ch;
    logic        sample_vld, short_err, fmt_err, lrck_lost;

    always #10 clk = ~clk;

    sp_rx_port u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .lrck(lrck), .sdata(sdata),
        .fmt(fmt), .width_sel(width_sel), .sample_data(sample_data),
        .sample_ch(sample_ch), .sample_vld(sample_vld), .short_err(short_err),
        .fmt_err(fmt_err), .lrck_lost(lrck_lost)
    );

    int checks = 0, fails = 0;
    logic done = 1'b0;
    logic clr = 1'b0;
    logic [23:0] cap_d [16];
    logic [2:0]  cap_c [16];
    int cap_n = 0, short_n = 0;

    always @(negedge clk) begin
        if (clr) begin
            cap_n   = 0;
            short_n = 0;
        end else begin
            if (sample_vld && cap_n < 16) begin
                cap_d[cap_n] = sample_data;
                cap_c[cap_n] = sample_ch;
                cap_n++;
            end
            if (short_err) short_n++;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int wbits(input logic [1:0] ws);
        case (ws) 2'd0: return 16; 2'd1: return 18; 2'd2: return 20; default: return 24; endcase
    endfunction

    function automatic logic [23:0] bext(input logic [23:0] v, input int w);
        logic signed [23:0] t;
        t = $signed(v << (24 - w));
        return 24'(t >>> (24 - w));
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; clr = 1'b1; sclk = 1'b0; lrck = 1'b0; sdata = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1; clr = 1'b0;
    endtask

    task automatic sbit(input logic lr, input logic b);
        sclk = 1'b0; lrck = lr; sdata = b;
        repeat (2) @(negedge clk);
        sclk = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_half(input logic [2:0] f, input logic lr, input int len, input int w, input logic [23:0] v);
        for (int i = 0; i < len; i++) begin
            logic b;
            b = 1'b1;
            if (f == 3'd1) begin
                if (i >= 1 && i <= w) b = v[w - i];
            end else if (f == 3'd2) begin
                if (i >= len - w) b = v[len - 1 - i];
            end else begin
                if (i < w) b = v[w - 1 - i];
            end
            sbit(lr, b);
        end
    endtask

    task automatic send_stereo(input logic [2:0] f, input logic [1:0] ws, input int llen, input int rlen,
                               input logic [23:0] lv, input logic [23:0] rv);
        logic left_lr;
        int w;
        w = wbits(ws);
        left_lr = (f == 3'd1) ? 1'b0 : 1'b1;
        fmt = f; width_sel = ws;
        sbit(~left_lr, 1'b0);
        sbit(~left_lr, 1'b0);
        send_half(f, left_lr, llen, w, lv);
        send_half(f, ~left_lr, rlen, w, rv);
        sbit(left_lr, 1'b1);
        sbit(left_lr, 1'b1);
        repeat (10) @(negedge clk);
    endtask

    task automatic send_ol(input logic [1:0] ws, input logic [5:0][23:0] vals);
        int wc;
        wc = wbits(ws);
        if (wc > 20) wc = 20;
        fmt = 3'd3; width_sel = ws;
        sbit(1'b0, 1'b0);
        sbit(1'b0, 1'b0);
        for (int p = 0; p < 128; p++) begin
            logic b;
            int k, j;
            k = p / 20; j = p % 20;
            b = 1'b1;
            if (k < 6 && j < wc) b = vals[k][wc - 1 - j];
            sbit((p < 64) ? 1'b1 : 1'b0, b);
        end
        sbit(1'b1, 1'b0);
        sbit(1'b1, 1'b0);
        repeat (10) @(negedge clk);
    endtask

    typedef struct packed {
        logic [2:0]  f;
        logic [1:0]  ws;
        logic [7:0]  len;
        logic [23:0] lv;
        logic [23:0] rv;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{3'd0, 2'd0, 8'd16, 24'h008001, 24'h007FFE},
        '{3'd0, 2'd3, 8'd32, 24'h800000, 24'h123456},
        '{3'd0, 2'd2, 8'd64, 24'h0ABCDE, 24'h080001},
        '{3'd1, 2'd0, 8'd32, 24'h00A5A5, 24'h005A5A},
        '{3'd1, 2'd2, 8'd24, 24'h0F0F0F, 24'h00F0F1},
        '{3'd1, 2'd3, 8'd32, 24'hC00003, 24'h3FFFFC},
        '{3'd2, 2'd1, 8'd32, 24'h020001, 24'h01FFFF},
        '{3'd2, 2'd3, 8'd24, 24'hFEDCBA, 24'h000001},
        '{3'd2, 2'd0, 8'd64, 24'h00C003, 24'h003FFC}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        @(negedge clk);
        chk(!sample_vld && !short_err && !fmt_err, "R1 flags", {29'd0, sample_vld, short_err, fmt_err}, 0);
        chk(sample_data == 24'd0 && sample_ch == 3'd0, "R1 data", {5'd0, sample_ch, sample_data}, 0);

        // R2/R3/R4/R5: table of stereo vectors
        foreach (VECS[n]) begin
            vec_t v;
            string tag;
            int w;
            v = VECS[n];
            w = wbits(v.ws);
            tag = (v.f == 3'd0) ? "R2/R5" : (v.f == 3'd1) ? "R3/R5" : "R4/R5";
            do_reset();
            send_stereo(v.f, v.ws, int'(v.len), int'(v.len), v.lv, v.rv);
            chk(cap_n == 2, tag, cap_n, 2);
            chk(cap_d[0] == bext(v.lv, w) && cap_c[0] == 3'd0, tag, {5'd0, cap_c[0], cap_d[0]}, {8'd0, bext(v.lv, w)});
            chk(cap_d[1] == bext(v.rv, w) && cap_c[1] == 3'd1, tag, {5'd0, cap_c[1], cap_d[1]}, {8'd1, bext(v.rv, w)});
            chk(short_n == 0, tag, short_n, 0);
        end

        // R6: six-channel line, 20-bit and 16-bit widths, 24 capped to 20
        begin
            logic [5:0][23:0] ov;
            logic [1:0] wsv [3];
            wsv[0] = 2'd2; wsv[1] = 2'd0; wsv[2] = 2'd3;
            ov[0] = 24'h080001; ov[1] = 24'h07FFFE; ov[2] = 24'h012345;
            ov[3] = 24'h0FEDCB; ov[4] = 24'h000000; ov[5] = 24'h0F0F0F;
            for (int t = 0; t < 3; t++) begin
                int wc;
                wc = wbits(wsv[t]);
                if (wc > 20) wc = 20;
                do_reset();
                send_ol(wsv[t], ov);
                chk(cap_n == 6, "R6 count", cap_n, 6);
                for (int k = 0; k < 6; k++) begin
                    chk(cap_d[k] == bext(ov[k], wc) && cap_c[k] == 3'(k), "R6/R10 slot",
                        {5'd0, cap_c[k], cap_d[k]}, {5'd0, 3'(k), bext(ov[k], wc)});
                end
                chk(short_n == 0, "R6 no short", short_n, 0);
            end
        end

        // R8: short halves
        do_reset();
        send_stereo(3'd0, 2'd3, 32, 16, 24'h654321, 24'h111111);
        chk(cap_n == 1 && cap_d[0] == 24'h654321, "R8 LJ keep left", cap_n, 1);
        chk(short_n == 1, "R8 LJ short", short_n, 1);
        do_reset();
        send_stereo(3'd1, 2'd0, 17, 16, 24'h00F00F, 24'h001234);
        chk(cap_n == 1 && cap_d[0] == bext(24'h00F00F, 16), "R8 I2S W+1 kept", {16'd0, 8'(cap_n), 8'd0}, 24'h000100);
        chk(short_n == 1, "R8 I2S W short", short_n, 1);

        // R7: reserved format codes
        do_reset();
        send_stereo(3'd4, 2'd0, 32, 32, 24'h001111, 24'h002222);
        chk(fmt_err == 1'b1, "R7 fmt_err code 4", fmt_err, 1);
        chk(cap_n == 0, "R7 no sample code 4", cap_n, 0);
        do_reset();
        send_stereo(3'd7, 2'd0, 32, 32, 24'h001111, 24'h002222);
        chk(fmt_err == 1'b1 && cap_n == 0, "R7 code 7", {31'd0, fmt_err}, 1);
        fmt = 3'd0;
        repeat (3) @(negedge clk);
        chk(fmt_err == 1'b0, "R7 clears", fmt_err, 0);

        // R9: frame clock lost
        do_reset();
        fmt = 3'd0; width_sel = 2'd0;
        sbit(1'b1, 1'b0);
        repeat (500) @(negedge clk);
        chk(lrck_lost == 1'b0, "R9 not yet lost", lrck_lost, 0);
        repeat (700) @(negedge clk);
        chk(lrck_lost == 1'b1, "R9 lost", lrck_lost, 1);
        sbit(1'b0, 1'b0);
        repeat (6) @(negedge clk);
        chk(lrck_lost == 1'b0, "R9 recovers", lrck_lost, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule